// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block keeps the few configuration bytes of a power-management function that place two relocatable 64-byte I/O windows, and turns them into address decode. One window holds the power-management registers and the other holds an SMBus controller. Each window has a base address and an enable bit, and both are taken from bytes written over a byte-addressed configuration write port. A single write can carry up to four bytes.

An incoming 16-bit I/O address is compared against both windows. Each window reports a hit and the local offset of the address inside the 64-byte window. When both windows would claim the same address, the power-management window wins.

The configuration write port is a valid/ready stream. Ready is low during reset and high at all other times, so no back-pressure happens outside reset. A write takes effect only on a clock edge where valid and ready are both high. A valid that is raised while ready is low is dropped; it is not held for later. A combinational byte read port lets the stored configuration be inspected.

Top module: `pmw_io_decoder`

## Requirements
- R1: After reset, the configuration bytes read as follows: offset 0x40 reads 0x01, offsets 0x41 to 0x43 and 0x80 read 0x00, offset 0x90 reads the low byte of SMB_INIT with bit 0 set, offset 0x91 reads the high byte of SMB_INIT, offsets 0x92 and 0x93 read 0x00, and offset 0xD2 reads 0x09. The power-management window starts disabled and the SMBus window starts enabled.
- R2: A write with offset O and length L (1 to 4) sets byte O+i to data bits [8i+7:8i] for each i below L, all on the same edge. A length of 0 writes nothing. Bytes past offset 0xFF are dropped. Offsets other than 0x40-0x43, 0x80, 0x90-0x93 and 0xD2 are not stored and read 0x00.
- R3: Bit 0 of offsets 0x40 and 0x90 always reads 1, whatever value is written.
- R4: The power-management base is {byte 0x41, byte 0x40} AND 0xFFC0. Bytes 0x42 and 0x43 are stored but have no effect on the decode.
- R5: The power-management window hits only while bit 0 of byte 0x80 is 1 and io_addr[15:6] equals base[15:6].
- R6: The SMBus base is {byte 0x91, byte 0x90} AND 0xFFC0. The SMBus window hits only while bit 0 of byte 0xD2 is 1 and io_addr[15:6] matches that base.
- R7: Each window's offset output equals io_addr[5:0].
- R8: When both windows match io_addr, pm_hit is 1 and smb_hit is 0.
- R9: A write accepted at a clock edge is visible on the read port and in the decode right after that edge. The decode does not change unless a write touches the bytes that define it.
- R10: cfg_wr_ready is 0 during reset and 1 from the first edge after reset. A write raised while ready is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Configuration write valid |
| cfg_wr_ready | output | 1 | Configuration write ready |
| cfg_wr_off | input | 8 | Byte offset of the first byte written |
| cfg_wr_len | input | 3 | Number of bytes to write, 0 to 4 |
| cfg_wr_data | input | 32 | Write data; lane i goes to offset+i |
| cfg_rd_off | input | 8 | Byte offset to read |
| cfg_rd_data | output | 8 | Stored byte at cfg_rd_off |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the power-management window |
| pm_off | output | 6 | Offset inside the power-management window |
| smb_hit | output | 1 | Address falls in the SMBus window and not in the power-management window |
| smb_off | output | 6 | Offset inside the SMBus window |

## Verification
The decode is probed at the first and last byte of each window and one step outside each edge. This separates a correct 64-byte match from a compare that uses the wrong bit slice. Some writes place unmasked low bits into the base, some change only bytes 0x42/0x43, and some straddle a defining byte from a neighbouring offset. Together these show whether masking, lane steering and the choice of defining bytes are right. Enable bits are toggled while the address stays fixed, the two windows are placed over each other to show priority, and writes of length 0 and writes made during reset must leave everything unchanged.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int CFG_AW    = 8;
  localparam int ADDR_W    = 16;
  localparam int WIN_LOG2  = 6;
  localparam int LANES     = 4;
  localparam int NUM_TRACK = 10;
  localparam int NUM_WIN   = 2;

  localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'((1 << WIN_LOG2) - 1);

  // index layout of tracked bytes: 0..3 pm base, 4 pm ctl, 5..8 smb base, 9 smb ctl
  localparam int IDX_PM_B0  = 0;
  localparam int IDX_PM_CTL = 4;
  localparam int IDX_SB_B0  = 5;
  localparam int IDX_SB_CTL = 9;

  typedef logic [7:0] cbyte_t;

  function automatic cbyte_t track_off(input int idx);
    case (idx)
      0: return 8'h40;
      1: return 8'h41;
      2: return 8'h42;
      3: return 8'h43;
      4: return 8'h80;
      5: return 8'h90;
      6: return 8'h91;
      7: return 8'h92;
      8: return 8'h93;
      default: return 8'hD2;
    endcase
  endfunction

  function automatic cbyte_t track_rst(input int idx, input logic [ADDR_W-1:0] smb_init);
    case (idx)
      0: return 8'h01;
      5: return smb_init[7:0] | 8'h01;
      6: return smb_init[15:8];
      9: return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic cbyte_t track_ro1(input int idx);
    return (idx == IDX_PM_B0 || idx == IDX_SB_B0) ? 8'h01 : 8'h00;
  endfunction

  function automatic int win_b0(input int w);
    return (w == 0) ? IDX_PM_B0 : IDX_SB_B0;
  endfunction

  function automatic int win_ctl(input int w);
    return (w == 0) ? IDX_PM_CTL : IDX_SB_CTL;
  endfunction
endpackage

// File: rtl/pmw_cfg_store.sv
module pmw_cfg_store
  import pmw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SMB_INIT = 16'hB100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [CFG_AW-1:0]             wr_off,
  input  logic [2:0]                    wr_len,
  input  logic [8*LANES-1:0]            wr_data,
  input  logic [CFG_AW-1:0]             rd_off,
  output logic [7:0]                    rd_data,
  output logic [NUM_TRACK-1:0][7:0]     nxt_bytes,
  output logic [NUM_TRACK-1:0]          touched
);
  logic [NUM_TRACK-1:0][7:0] cur_bytes;

  for (genvar g = 0; g < NUM_TRACK; g++) begin : g_byte
    localparam cbyte_t OFF = track_off(g);
    localparam cbyte_t RST = track_rst(g, SMB_INIT);
    localparam cbyte_t RO1 = track_ro1(g);

    logic [7:0] lane_val;
    logic       lane_hit;

    always_comb begin
      lane_val = cur_bytes[g];
      lane_hit = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (wr_en && (l < int'(wr_len)) &&
            ((9'(wr_off) + 9'(l)) == 9'(OFF))) begin
          lane_val = wr_data[8*l +: 8];
          lane_hit = 1'b1;
        end
      end
    end

    assign nxt_bytes[g] = lane_val | RO1;
    assign touched[g]   = lane_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) cur_bytes[g] <= RST;
      else        cur_bytes[g] <= nxt_bytes[g];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_TRACK; i++) begin
      if (rd_off == track_off(i)) rd_data = cur_bytes[i];
    end
  end
endmodule

// File: rtl/pmw_win_decode.sv
module pmw_win_decode
  import pmw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RST_BASE = '0,
  parameter logic              RST_EN   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh,
  input  logic [7:0]          base_lo,
  input  logic [7:0]          base_hi,
  input  logic [7:0]          ctl,
  input  logic [ADDR_W-1:0]   io_addr,
  output logic                hit,
  output logic [WIN_LOG2-1:0] off
);
  logic [ADDR_W-1:0] base_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= RST_BASE & BASE_MASK;
      en_q   <= RST_EN;
    end else if (refresh) begin
      base_q <= {base_hi, base_lo} & BASE_MASK;
      en_q   <= ctl[0];
    end
  end

  assign hit = en_q && (io_addr[ADDR_W-1:WIN_LOG2] == base_q[ADDR_W-1:WIN_LOG2]);
  assign off = io_addr[WIN_LOG2-1:0];
endmodule

// File: rtl/pmw_io_decoder.sv
module pmw_io_decoder
  import pmw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SMB_INIT = 16'hB100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_valid,
  output logic                 cfg_wr_ready,
  input  logic [CFG_AW-1:0]    cfg_wr_off,
  input  logic [2:0]           cfg_wr_len,
  input  logic [8*LANES-1:0]   cfg_wr_data,
  input  logic [CFG_AW-1:0]    cfg_rd_off,
  output logic [7:0]           cfg_rd_data,
  input  logic [ADDR_W-1:0]    io_addr,
  output logic                 pm_hit,
  output logic [WIN_LOG2-1:0]  pm_off,
  output logic                 smb_hit,
  output logic [WIN_LOG2-1:0]  smb_off
);
  logic                      ready_q;
  logic                      wr_acc;
  logic [NUM_TRACK-1:0][7:0] nxt_bytes;
  logic [NUM_TRACK-1:0]      touched;
  logic [NUM_WIN-1:0]        raw_hit;
  logic [NUM_WIN-1:0][WIN_LOG2-1:0] raw_off;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign cfg_wr_ready = ready_q;
  assign wr_acc       = cfg_wr_valid && ready_q;

  pmw_cfg_store #(.SMB_INIT(SMB_INIT)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_acc),
    .wr_off    (cfg_wr_off),
    .wr_len    (cfg_wr_len),
    .wr_data   (cfg_wr_data),
    .rd_off    (cfg_rd_off),
    .rd_data   (cfg_rd_data),
    .nxt_bytes (nxt_bytes),
    .touched   (touched)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int B0  = win_b0(w);
    localparam int CTL = win_ctl(w);
    localparam logic [ADDR_W-1:0] RB = (w == 0) ? '0 : SMB_INIT;
    localparam logic              RE = (w == 0) ? 1'b0 : 1'b1;

    logic refresh;
    assign refresh = touched[B0] | touched[B0+1] | touched[B0+2] |
                     touched[B0+3] | touched[CTL];

    pmw_win_decode #(.RST_BASE(RB), .RST_EN(RE)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .refresh (refresh),
      .base_lo (nxt_bytes[B0]),
      .base_hi (nxt_bytes[B0+1]),
      .ctl     (nxt_bytes[CTL]),
      .io_addr (io_addr),
      .hit     (raw_hit[w]),
      .off     (raw_off[w])
    );
  end

  assign pm_hit  = raw_hit[0];
  assign pm_off  = raw_off[0];
  assign smb_hit = raw_hit[1] & ~raw_hit[0];
  assign smb_off = raw_off[1];
endmodule

module pmw_io_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_valid,
  input logic        cfg_wr_ready,
  input logic [7:0]  cfg_wr_off,
  input logic [2:0]  cfg_wr_len,
  input logic [31:0] cfg_wr_data,
  input logic [15:0] io_addr,
  input logic        pm_hit,
  input logic        smb_hit
);
  logic acc;
  assign acc = cfg_wr_valid && cfg_wr_ready;

  AST_PM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> !smb_hit); // R8

  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cfg_wr_ready); // R10

  AST_DECODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(io_addr) -> ($stable(pm_hit) && $stable(smb_hit)))); // R9

  AST_PM_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_wr_off == 8'h80 && cfg_wr_len == 3'd1 && !cfg_wr_data[0]) |=> !pm_hit); // R5

  AST_SMB_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_wr_off == 8'hD2 && cfg_wr_len == 3'd1 && !cfg_wr_data[0]) |=> !smb_hit); // R6
endmodule

bind pmw_io_decoder pmw_io_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_valid (cfg_wr_valid),
  .cfg_wr_ready (cfg_wr_ready),
  .cfg_wr_off   (cfg_wr_off),
  .cfg_wr_len   (cfg_wr_len),
  .cfg_wr_data  (cfg_wr_data),
  .io_addr      (io_addr),
  .pm_hit       (pm_hit),
  .smb_hit      (smb_hit)
);

// File: tb/test_pmw_io_decoder.sv
module test_pmw_io_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_valid = 1'b0;
  logic        cfg_wr_ready;
  logic [7:0]  cfg_wr_off = '0;
  logic [2:0]  cfg_wr_len = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [7:0]  cfg_rd_off = '0;
  logic [7:0]  cfg_rd_data;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [5:0]  pm_off, smb_off;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct packed {
    logic [15:0] addr;
    logic        pmh;
    logic        smbh;
    logic [5:0]  off;
    logic [7:0]  req;
  } exp_t;
  exp_t q[$];
  logic probe_v = 1'b0;

  logic [7:0] m [256];

  always #2 clk = ~clk;

  pmw_io_decoder i_pmw_io_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready),
    .cfg_wr_off(cfg_wr_off), .cfg_wr_len(cfg_wr_len), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_off(cfg_rd_off), .cfg_rd_data(cfg_rd_data),
    .io_addr(io_addr), .pm_hit(pm_hit), .pm_off(pm_off),
    .smb_hit(smb_hit), .smb_off(smb_off)
  );

  function automatic bit tracked(input logic [7:0] o);
    return (o >= 8'h40 && o <= 8'h43) || o == 8'h80 ||
           (o >= 8'h90 && o <= 8'h93) || o == 8'hD2;
  endfunction

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: one write beat; model follows the requirements (R2, R3)
  task automatic cfg_write(input logic [7:0] off, input logic [2:0] len, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_off = off; cfg_wr_len = len; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    for (int l = 0; l < 4; l++)
      if (l < int'(len) && int'(off) + l <= 255) m[int'(off) + l] = data[8*l +: 8];
    m[8'h40][0] = 1'b1;
    m[8'h90][0] = 1'b1;
  endtask

  task automatic rd_check(input logic [7:0] off, input int req);
    @(negedge clk);
    cfg_rd_off = off;
    #1;
    check(req, 32'(cfg_rd_data), tracked(off) ? 32'(m[off]) : 32'h0, $sformatf("read byte %h", off));
  endtask

  // driver: pushes the expected decode for one address
  task automatic probe(input logic [15:0] a, input int req);
    exp_t e;
    logic [15:0] pb, sb;
    logic ph, sh;
    pb = {m[8'h41], m[8'h40]} & 16'hFFC0;
    sb = {m[8'h91], m[8'h90]} & 16'hFFC0;
    ph = m[8'h80][0] && (a[15:6] == pb[15:6]);
    sh = m[8'hD2][0] && (a[15:6] == sb[15:6]) && !ph;
    e = '{addr: a, pmh: ph, smbh: sh, off: a[5:0], req: 8'(req)};
    @(negedge clk);
    io_addr = a;
    q.push_back(e);
    probe_v = 1'b1;
    @(negedge clk);
    probe_v = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    if (probe_v && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(int'(e.req), 32'(pm_hit),  32'(e.pmh),  $sformatf("pm_hit @%h", e.addr));
      check(int'(e.req), 32'(smb_hit), 32'(e.smbh), $sformatf("smb_hit @%h", e.addr));
      check(7, 32'(pm_off),  32'(e.off), $sformatf("pm_off @%h", e.addr));  // R7
      check(7, 32'(smb_off), 32'(e.off), $sformatf("smb_off @%h", e.addr)); // R7
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[8'h40] = 8'h01; m[8'h90] = 8'h01; m[8'h91] = 8'hB1; m[8'hD2] = 8'h09;

    // R10: write during reset is dropped, ready low
    repeat (2) @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_off = 8'h80; cfg_wr_len = 3'd1; cfg_wr_data = 32'h1;
    #1 check(10, 32'(cfg_wr_ready), 32'h0, "ready in reset"); // R10
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(10, 32'(cfg_wr_ready), 32'h1, "ready after reset"); // R10

    // R1 reset values
    rd_check(8'h40, 1); rd_check(8'h43, 1); rd_check(8'h80, 1); // R1
    rd_check(8'h90, 1); rd_check(8'h91, 1); rd_check(8'hD2, 1); // R1
    rd_check(8'h55, 2); // R2 untracked
    probe(16'hB105, 1);  // R1 smb enabled
    probe(16'h0005, 1);  // R1 pm disabled

    // R3, R4: low bits masked, pm still disabled
    cfg_write(8'h40, 3'd4, 32'hFFFF_1234);
    rd_check(8'h40, 3); rd_check(8'h42, 2); // R3 R2
    probe(16'h1210, 5); // R5 disabled

    // R5 enable, edges of window, R9 immediately after write
    cfg_write(8'h80, 3'd1, 32'h1);
    probe(16'h1210, 9);  // R9
    probe(16'h1200, 5); probe(16'h123F, 5); probe(16'h1240, 5); probe(16'h11FF, 5); // R5

    // R4: bytes 0x42/0x43 do not move the window
    cfg_write(8'h42, 3'd2, 32'h0000_0000);
    probe(16'h1200, 4); probe(16'h0000, 4); // R4

    // R8 overlap with smb window
    cfg_write(8'h40, 3'd2, 32'h0000_B13F);
    probe(16'hB12A, 8); // R8

    cfg_write(8'h80, 3'd1, 32'h0);
    probe(16'hB12A, 6); // R6 smb now wins alone
    cfg_write(8'hD2, 3'd1, 32'h0);
    probe(16'hB12A, 6); // R6 disabled

    // R2 lane steering across defining bytes
    cfg_write(8'h8E, 3'd4, 32'h0101_AAAA);
    rd_check(8'h90, 3); rd_check(8'h8F, 2); // R3 R2
    cfg_write(8'hD0, 3'd4, 32'h0001_0000);
    probe(16'h0107, 6); probe(16'h0147, 6); // R6
    cfg_write(8'h3E, 3'd4, 32'h0300_7777);
    rd_check(8'h40, 2); rd_check(8'h41, 2); // R2

    // R2 length zero writes nothing
    cfg_write(8'h80, 3'd0, 32'h0000_0001);
    rd_check(8'h80, 2); // R2
    probe(16'h0300, 2); // R2 pm stays disabled
    cfg_write(8'h80, 3'd1, 32'h1);
    probe(16'h0300, 5); probe(16'h0107, 8); // R5 R8

    // R2 bytes past 0xFF are dropped
    cfg_write(8'hFE, 3'd4, 32'hFFFF_FFFF);
    rd_check(8'h00, 2); rd_check(8'h01, 2); // R2
    probe(16'h0300, 9); // R9 decode unchanged

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    done = 1;
    $finish;
  end
endmodule